// File: doc/BRIEF.md
# Windowed Out-of-Lock Detector

This block judges whether a timestamp-recovery clock loop is holding lock. Once per timestamp period it receives a tick, and with each tick two flags: one saying the compared timestamp value fell outside the accepted window, and one saying a downstream filter loop saw a lock slip. The block groups the ticks into back-to-back observation windows of sixteen periods. For each flag it counts the flagged periods in the window and compares the count with that flag's own 4-bit threshold. A count above the threshold raises a sticky out-of-lock flag, and software clears it with a clear-on-read strobe.

Next to the windowed test, a saturating counter records every out-of-window value, whatever the loop state. While the receive FIFO fills for the first time, the loop runs free. The block reports this on a status output and does no window counting. Once the FIFO reports its start-up fill level, the next period tick aligns the first window. Counting starts with the tick after it.

Top module: `lock_window_monitor`

## Requirements
- R1: A tick with `out_win_i` high increments `invalid_cnt_o` by one in the next cycle, in every phase. No other stimulus changes it.
- R2: `invalid_cnt_o` is 16 bits wide. It stops at 65535 and does not wrap.
- R3: `free_run_o` is 1 from reset until the cycle after `fifo_primed_i` is first sampled high. It then stays 0 until reset.
- R4: Ticks seen while `free_run_o` is 1 do not count, and neither does the first tick after it falls. That tick only sets the start of the first window.
- R5: A window is 16 consecutive counted ticks. The event on the 16th tick is part of the window. Counting restarts from zero for the next window.
- R6: `unlock_main_o` becomes 1 in the cycle after a window's last tick if the window's count of `out_win_i` events is strictly greater than `thr_main_i` (unsigned, 0 to 15).
- R7: `unlock_filt_o` applies the same test to `filt_slip_i` events against `thr_filt_i`, independently of R6.
- R8: Both out-of-lock flags are sticky. A `clr_i` pulse sets them to 0 in the next cycle.
- R9: If a window sets a flag in the same cycle as `clr_i`, the flag is 1 afterwards.
- R10: After reset both flags are 0, `invalid_cnt_o` is 0 and `free_run_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per timestamp period |
| out_win_i | input | 1 | Timestamp value outside accepted window, qualified by tick_i |
| filt_slip_i | input | 1 | Filter-loop lock slip, qualified by tick_i |
| thr_main_i | input | 4 | Threshold for the main out-of-lock test |
| thr_filt_i | input | 4 | Threshold for the filter out-of-lock test |
| fifo_primed_i | input | 1 | Receive FIFO has reached its start-up fill level |
| clr_i | input | 1 | Clear-on-read strobe for both out-of-lock flags |
| free_run_o | output | 1 | Loop free running during FIFO start-up |
| unlock_main_o | output | 1 | Sticky main out-of-lock flag |
| unlock_filt_o | output | 1 | Sticky filter out-of-lock flag |
| invalid_cnt_o | output | 16 | Saturating count of out-of-window values |

## Verification
A period index out of step with the bench's window boundaries shows up one cycle after the 16th tick. A flag appears a window early or late, or a count that lands just above a threshold is missed. A window counter that leaks counts from one window into the next, or counts the aligning tick, turns an expected 0 flag into 1 at the first boundary that follows. An invalid counter that drifts or wraps differs from the bench's running model at the next window check.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
    typedef enum logic [1:0] {
        PH_FREE = 2'd0,
        PH_ARM  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;
endpackage

// File: rtl/lwm_phase_ctl.sv
module lwm_phase_ctl
    import lwm_pkg::*;
#(
    parameter int WIN_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic primed_i,
    input  logic tick_i,
    output logic free_run_o,
    output logic count_en_o,
    output logic win_end_o
);
    localparam int IDX_W = $clog2(WIN_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        count_en_o = tick_i && (state_q.phase == PH_RUN);
        win_end_o  = count_en_o && (state_q.idx == LAST_IDX);
        case (state_q.phase)
            PH_FREE: if (primed_i) state_d.phase = PH_ARM;
            PH_ARM:  if (tick_i) begin
                state_d.phase = PH_RUN;
                state_d.idx   = '0;
            end
            PH_RUN:  if (count_en_o) begin
                state_d.idx = win_end_o ? '0 : state_q.idx + 1'b1;
            end
            default: state_d.phase = PH_FREE;
        endcase
        free_run_o = (state_q.phase == PH_FREE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{phase: PH_FREE, idx: '0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/lwm_window_chan.sv
module lwm_window_chan #(
    parameter int WIN_LEN = 16,
    parameter int THR_W   = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             count_en_i,
    input  logic             win_end_i,
    input  logic             ev_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             clr_i,
    output logic             flag_o
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } state_t;

    state_t           state_d, state_q;
    logic [CNT_W-1:0] total;
    logic             set_hit;

    always_comb begin
        state_d = state_q;
        total   = state_q.cnt + CNT_W'(ev_i);
        set_hit = win_end_i && (total > CNT_W'(thr_i));
        if (count_en_i) begin
            state_d.cnt = win_end_i ? '0 : total;
        end
        state_d.flag = set_hit || (state_q.flag && !clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;
endmodule

// File: rtl/lwm_sat_counter.sv
module lwm_sat_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] TOP = '1;

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lock_window_monitor.sv
module lock_window_monitor #(
    parameter int WIN_LEN = 16,
    parameter int THR_W   = 4,
    parameter int INV_W   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             out_win_i,
    input  logic             filt_slip_i,
    input  logic [THR_W-1:0] thr_main_i,
    input  logic [THR_W-1:0] thr_filt_i,
    input  logic             fifo_primed_i,
    input  logic             clr_i,
    output logic             free_run_o,
    output logic             unlock_main_o,
    output logic             unlock_filt_o,
    output logic [INV_W-1:0] invalid_cnt_o
);
    localparam int N_CHAN = 2;

    logic             count_en_w;
    logic             win_end_w;
    logic [N_CHAN-1:0]            ev_w;
    logic [N_CHAN-1:0][THR_W-1:0] thr_w;
    logic [N_CHAN-1:0]            flag_w;

    assign ev_w  = {filt_slip_i, out_win_i};
    assign thr_w = {thr_filt_i, thr_main_i};

    lwm_phase_ctl #(.WIN_LEN(WIN_LEN)) u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .primed_i   (fifo_primed_i),
        .tick_i     (tick_i),
        .free_run_o (free_run_o),
        .count_en_o (count_en_w),
        .win_end_o  (win_end_w)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        lwm_window_chan #(.WIN_LEN(WIN_LEN), .THR_W(THR_W)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .count_en_i (count_en_w),
            .win_end_i  (win_end_w),
            .ev_i       (ev_w[c]),
            .thr_i      (thr_w[c]),
            .clr_i      (clr_i),
            .flag_o     (flag_w[c])
        );
    end

    lwm_sat_counter #(.WIDTH(INV_W)) u_inv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (tick_i && out_win_i),
        .cnt_o  (invalid_cnt_o)
    );

    assign unlock_main_o = flag_w[0];
    assign unlock_filt_o = flag_w[1];
endmodule

// File: rtl/lwm_checker.sv
module lwm_checker #(
    parameter int INV_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             out_win_i,
    input logic             fifo_primed_i,
    input logic             clr_i,
    input logic             win_end_w,
    input logic             free_run_o,
    input logic             unlock_main_o,
    input logic             unlock_filt_o,
    input logic [INV_W-1:0] invalid_cnt_o
);
    localparam logic [INV_W-1:0] CAP = '1;

    // R1
    inv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && out_win_i && invalid_cnt_o != CAP) |=> invalid_cnt_o == $past(invalid_cnt_o) + 1'b1);

    // R1
    inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tick_i && out_win_i) |=> $stable(invalid_cnt_o));

    // R2
    inv_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (invalid_cnt_o == CAP) |=> invalid_cnt_o == CAP);

    // R3
    free_stay_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !free_run_o |=> !free_run_o);

    // R3
    free_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_run_o && !fifo_primed_i) |=> free_run_o);

    // R4
    no_flag_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_run_o |-> !unlock_main_o && !unlock_filt_o);

    // R6
    main_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(unlock_main_o) |-> $past(win_end_w));

    // R7
    filt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(unlock_filt_o) |-> $past(win_end_w));

    // R8
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unlock_main_o && !clr_i) |=> unlock_main_o);

    // R8
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !win_end_w) |=> !unlock_main_o && !unlock_filt_o);
endmodule

bind lock_window_monitor lwm_checker #(.INV_W(INV_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .out_win_i     (out_win_i),
    .fifo_primed_i (fifo_primed_i),
    .clr_i         (clr_i),
    .win_end_w     (win_end_w),
    .free_run_o    (free_run_o),
    .unlock_main_o (unlock_main_o),
    .unlock_filt_o (unlock_filt_o),
    .invalid_cnt_o (invalid_cnt_o)
);

// File: tb/lock_window_monitor_tb.sv
module lock_window_monitor_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        out_win_i = 1'b0;
    logic        filt_slip_i = 1'b0;
    logic [3:0]  thr_main_i = '0;
    logic [3:0]  thr_filt_i = '0;
    logic        fifo_primed_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        free_run_o;
    logic        unlock_main_o;
    logic        unlock_filt_o;
    logic [15:0] invalid_cnt_o;

    int checks = 0;
    int failures = 0;
    int exp_inv = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    lock_window_monitor u_dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick_i),
        .out_win_i     (out_win_i),
        .filt_slip_i   (filt_slip_i),
        .thr_main_i    (thr_main_i),
        .thr_filt_i    (thr_filt_i),
        .fifo_primed_i (fifo_primed_i),
        .clr_i         (clr_i),
        .free_run_o    (free_run_o),
        .unlock_main_o (unlock_main_o),
        .unlock_filt_o (unlock_filt_o),
        .invalid_cnt_o (invalid_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock cycle with the given inputs, ending at the next falling edge
    task automatic cycle(input bit tk, input bit ow, input bit fs, input bit cl, input bit pr);
        tick_i = tk; out_win_i = ow; filt_slip_i = fs; clr_i = cl; fifo_primed_i = pr;
        @(negedge clk_i);
        if (tk && ow && exp_inv < 65535) exp_inv++;
        tick_i = 1'b0; out_win_i = 1'b0; filt_slip_i = 1'b0; clr_i = 1'b0; fifo_primed_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R10 reset state
        check("R10 free_run", free_run_o, 1);
        check("R10 unlock_main", unlock_main_o, 0);
        check("R10 unlock_filt", unlock_filt_o, 0);
        check("R10 invalid_cnt", invalid_cnt_o, 0);

        // R4: events during free run never count; R1 counts them anyway
        thr_main_i = 4'd0; thr_filt_i = 4'd0;
        for (int k = 0; k < 20; k++) cycle(1, 1, 1, 0, 0);
        check("R4 free-run main", unlock_main_o, 0);
        check("R4 free-run filt", unlock_filt_o, 0);
        check("R3 still free", free_run_o, 1);
        check("R1 free-run count", invalid_cnt_o, exp_inv);

        // R3: primed drops free-run next cycle
        cycle(0, 0, 0, 0, 1);
        check("R3 free_run falls", free_run_o, 0);
        cycle(0, 0, 0, 0, 0);
        check("R3 stays low", free_run_o, 0);

        // R4: aligning tick carries events that must not count
        cycle(1, 1, 1, 0, 0);
        for (int k = 0; k < 15; k++) cycle(1, 0, 0, 0, 0);
        check("R4 aligning tick main", unlock_main_o, 0);
        check("R4 aligning tick filt", unlock_filt_o, 0);
        cycle(1, 0, 0, 0, 0);
        check("R5 empty window main", unlock_main_o, 0);
        check("R5 empty window filt", unlock_filt_o, 0);

        // R5 R6 R7 R8: sweep thresholds and event counts
        for (int t = 0; t < 16; t++) begin
            for (int n = 0; n <= 16; n++) begin
                int m;
                int tf;
                m  = (n * 7 + t * 3) % 17;
                tf = (t * 5 + 1) % 16;
                thr_main_i = 4'(t);
                thr_filt_i = 4'(tf);
                for (int k = 0; k < 16; k++) begin
                    cycle(1, k < n, (15 - k) < m, 0, 0);
                    if (k == 14) begin
                        check("R5 no early flag main", unlock_main_o, 0);
                    end
                end
                check("R6 main compare", unlock_main_o, (n > t) ? 1 : 0);
                check("R7 filt compare", unlock_filt_o, (m > tf) ? 1 : 0);
                check("R1 running count", invalid_cnt_o, exp_inv);
                cycle(0, 0, 0, 0, 0);
                check("R8 sticky main", unlock_main_o, (n > t) ? 1 : 0);
                cycle(0, 0, 0, 1, 0);
                check("R8 clear main", unlock_main_o, 0);
                check("R8 clear filt", unlock_filt_o, 0);
            end
        end

        // R9: set and clear in the same cycle, set wins
        thr_main_i = 4'd0; thr_filt_i = 4'd0;
        for (int k = 0; k < 15; k++) cycle(1, k == 3, k == 7, 0, 0);
        cycle(1, 0, 0, 1, 0);
        check("R9 main set over clear", unlock_main_o, 1);
        check("R9 filt set over clear", unlock_filt_o, 1);
        cycle(0, 0, 0, 1, 0);
        check("R8 clear after R9", unlock_main_o, 0);

        // R2: saturation
        while (exp_inv < 65535) cycle(1, 1, 0, 0, 0);
        check("R2 reaches cap", invalid_cnt_o, 65535);
        for (int k = 0; k < 5; k++) cycle(1, 1, 0, 0, 0);
        check("R2 no wrap", invalid_cnt_o, 65535);
        check("R3 free_run low at end", free_run_o, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk_i);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule